// File: doc/BRIEF.md
# Byte-Wide Timer Register Interface

This block is the host-facing register port of a three-channel, 16-bit interval timer. The host reaches it over an 8-bit data bus with a chip select, read and write strobes, and a 2-bit address. Addresses 0, 1 and 2 reach the count registers of the three channels. Address 3 takes control bytes, which configure a channel or freeze its live count for a read.

Each 16-bit value crosses the 8-bit bus as one or two bytes. A per-channel byte-order flip-flop for each direction sets the order. Once a load is complete, the block hands the counting logic a one-cycle load strobe and the full initial count. It also presents each channel's operating mode and its binary/BCD flag. A latch command copies the counter's live value into a hold register. That copy stays put until the host has read it out completely, so a two-byte read never mixes bytes from two different counts.

Top module: `tmr_bus_if`

## Requirements
- R1: Bus strobes take effect only while `sel` is high. A write with `sel` low produces no load strobe and changes no configuration or byte-order state. When `rd` and `wr` are high together, the write is served and the read is ignored.
- R2: A write to address 3 is a control byte. Bits 7:6 select the channel, bits 5:4 the access kind, bits 3:1 the mode and bit 0 the BCD flag. If the access kind is not 00, the channel's `ch_mode` and `ch_bcd` take the new values on the next clock.
- R3: A control byte with access kind 00 is a latch command. It copies the channel's `live_cnt` into a hold register, pulses that channel's `latch_req` high for one cycle, and leaves mode, BCD flag and access kind unchanged.
- R4: While a hold is pending, later latch commands to that channel are ignored (no `latch_req` pulse), and reads return the held value regardless of changes on `live_cnt`.
- R5: The hold is released after the final byte of the access kind has been read: one read for low-only or high-only access, two for word access. Reads after that return the live count.
- R6: With access kind 11 (word), the first write to a channel supplies the low byte and produces no strobe. The second write supplies the high byte, after which `ld_stb` pulses with `ld_val` = {high, low}.
- R7: With access kind 01 (low-only), each write pulses `ld_stb` with the high byte zero. With 10 (high-only), each write pulses it with the low byte zero.
- R8: A read from addresses 0 to 2 returns on `rdata` the byte chosen by the access kind. Word access alternates low then high. Low-only and high-only return that byte on every read. A read from address 3, or with no read active, returns 0.
- R9: A control byte that configures a channel returns both of its byte-order flip-flops to expect the low byte.
- R10: A control byte with bits 7:6 = 11 has no effect on any channel.
- R11: After reset, every channel has mode 0, BCD flag 0, word access and no pending hold. All of `ld_stb`, `latch_req` and `ld_val` are zero.
- R12: `ld_stb` is high only in the cycle after the clock edge that captured the final write, and at most one channel strobes in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 1 | Chip select, qualifies rd and wr |
| rd | input | 1 | Read strobe, one cycle per byte |
| wr | input | 1 | Write strobe, one cycle per byte |
| addr | input | 2 | 0..2 channel count, 3 control |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte (combinational) |
| live_cnt | input | 48 | Current count of each channel, channel 0 in bits 15:0 |
| ch_mode | output | 9 | Mode per channel, 3 bits each |
| ch_bcd | output | 3 | BCD flag per channel |
| ld_stb | output | 3 | One-cycle load strobe per channel |
| ld_val | output | 48 | Initial count per channel |
| latch_req | output | 3 | One-cycle pulse when a hold is captured |

## Verification
The hardest state to reach is a pending hold that overlaps other activity on the same channel. Examples are a half-finished word read, a second latch command, a new control byte that resets the read order, and a live count that keeps changing. In each case the bytes returned must still come from the frozen snapshot. Directed sequences build these overlaps on purpose. A seeded random phase then mixes control bytes, latch commands, byte writes, reads and live-count changes on all three channels, and compares each result with a reference model held in the bench.

// File: rtl/tmr_bus_pkg.sv
// Shared types for the timer register interface.
package tmr_bus_pkg;
    // Access kind field of a control byte
    typedef enum logic [1:0] {
        ACC_LATCH = 2'b00,
        ACC_LO    = 2'b01,
        ACC_HI    = 2'b10,
        ACC_WORD  = 2'b11
    } acc_e;

    localparam logic [1:0] CTRL_ADDR = 2'd3;
endpackage

// File: rtl/tmr_bus_decode.sv
// Address and control-byte decoder.
// Turns the bus strobes into per-channel hit signals and splits a control
// byte into its fields. Assumes single-cycle rd/wr strobes; when rd and wr
// are high together, only the write is decoded.
module tmr_bus_decode
    import tmr_bus_pkg::*;
#(
    parameter int NCH = 3,
    parameter int DW  = 8
) (
    input  logic          sel,
    input  logic          rd,
    input  logic          wr,
    input  logic [1:0]    addr,
    input  logic [DW-1:0] wdata,
    output logic [NCH-1:0] wr_hit,
    output logic [NCH-1:0] rd_hit,
    output logic [NCH-1:0] cfg_we,
    output logic [NCH-1:0] latch_cmd,
    output acc_e          cfg_acc,
    output logic [2:0]    cfg_mode,
    output logic          cfg_bcd
);
    logic       ctl_hit;
    logic [1:0] ctl_ch;

    // Field extraction of the control byte
    always_comb begin
        ctl_hit  = sel && wr && (addr == CTRL_ADDR);
        ctl_ch   = wdata[7:6];
        cfg_acc  = acc_e'(wdata[5:4]);
        cfg_mode = wdata[3:1];
        cfg_bcd  = wdata[0];
    end

    genvar i;
    generate
        for (i = 0; i < NCH; i++) begin : g_hit
            // Per-channel strobe decode
            always_comb begin
                wr_hit[i]    = sel && wr && (addr == 2'(i));
                rd_hit[i]    = sel && rd && !wr && (addr == 2'(i));
                cfg_we[i]    = ctl_hit && (ctl_ch == 2'(i)) && (cfg_acc != ACC_LATCH);
                latch_cmd[i] = ctl_hit && (ctl_ch == 2'(i)) && (cfg_acc == ACC_LATCH);
            end
        end
    endgenerate
endmodule

// File: rtl/tmr_bus_chan.sv
// One channel's register port.
// Holds mode, BCD flag and access kind; sequences byte writes into a
// 16-bit load; keeps the latch hold register; selects the read byte.
// Assumes cfg_we, latch_cmd, wr_hit and rd_hit are mutually exclusive.
module tmr_bus_chan
    import tmr_bus_pkg::*;
#(
    parameter int DW = 8,
    localparam int CW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  acc_e          cfg_acc,
    input  logic [2:0]    cfg_mode,
    input  logic          cfg_bcd,
    input  logic          latch_cmd,
    input  logic          wr_hit,
    input  logic          rd_hit,
    input  logic [DW-1:0] wdata,
    input  logic [CW-1:0] live,
    output logic [2:0]    mode,
    output logic          bcd,
    output logic          ld_stb,
    output logic [CW-1:0] ld_val,
    output logic          latch_req,
    output logic [DW-1:0] rd_byte
);
    acc_e          acc_q;
    logic          wr_ff;
    logic          rd_ff;
    logic          latched;
    logic [DW-1:0] lo_buf;
    logic [CW-1:0] hold;
    logic [CW-1:0] src;

    // Configuration, write sequencing, latch capture and read ordering
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q     <= ACC_WORD;
            mode      <= '0;
            bcd       <= 1'b0;
            wr_ff     <= 1'b0;
            rd_ff     <= 1'b0;
            latched   <= 1'b0;
            lo_buf    <= '0;
            hold      <= '0;
            ld_stb    <= 1'b0;
            ld_val    <= '0;
            latch_req <= 1'b0;
        end else begin
            ld_stb    <= 1'b0;
            latch_req <= 1'b0;
            if (cfg_we) begin
                acc_q <= cfg_acc;
                mode  <= cfg_mode;
                bcd   <= cfg_bcd;
                wr_ff <= 1'b0;
                rd_ff <= 1'b0;
            end
            if (latch_cmd && !latched) begin
                hold      <= live;
                latched   <= 1'b1;
                latch_req <= 1'b1;
            end
            if (wr_hit) begin
                unique case (acc_q)
                    ACC_LO: begin
                        ld_val <= {{DW{1'b0}}, wdata};
                        ld_stb <= 1'b1;
                    end
                    ACC_HI: begin
                        ld_val <= {wdata, {DW{1'b0}}};
                        ld_stb <= 1'b1;
                    end
                    ACC_WORD: begin
                        if (!wr_ff) begin
                            lo_buf <= wdata;
                            wr_ff  <= 1'b1;
                        end else begin
                            ld_val <= {wdata, lo_buf};
                            ld_stb <= 1'b1;
                            wr_ff  <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
            if (rd_hit) begin
                if (acc_q == ACC_WORD) rd_ff <= !rd_ff;
                if (latched && (acc_q != ACC_WORD || rd_ff)) latched <= 1'b0;
            end
        end
    end

    // Read byte selection from the hold or the live count
    always_comb begin
        src = latched ? hold : live;
        unique case (acc_q)
            ACC_LO:   rd_byte = src[DW-1:0];
            ACC_HI:   rd_byte = src[CW-1:DW];
            ACC_WORD: rd_byte = rd_ff ? src[CW-1:DW] : src[DW-1:0];
            default:  rd_byte = '0;
        endcase
    end

    p_first_byte_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && acc_q == ACC_WORD && !wr_ff) |=> !ld_stb);
    p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (latched && !rd_hit) |=> (latched && $stable(hold)));
    p_release_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (latched && rd_hit && acc_q != ACC_WORD) |=> !latched);
    p_order_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (!wr_ff && !rd_ff));
    p_strobe_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ld_stb |-> $past(wr_hit));
endmodule

// File: rtl/tmr_bus_if.sv
// Top of the byte-wide timer register interface.
// Decodes the bus, instantiates one channel port per timer and merges
// the read bytes. Assumes synchronous single-cycle strobes in the clk domain.
module tmr_bus_if
    import tmr_bus_pkg::*;
#(
    parameter int NCH = 3,
    parameter int DW  = 8,
    localparam int CW = 2 * DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              rd,
    input  logic              wr,
    input  logic [1:0]        addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    input  logic [NCH*CW-1:0] live_cnt,
    output logic [NCH*3-1:0]  ch_mode,
    output logic [NCH-1:0]    ch_bcd,
    output logic [NCH-1:0]    ld_stb,
    output logic [NCH*CW-1:0] ld_val,
    output logic [NCH-1:0]    latch_req
);
    logic [NCH-1:0]    wr_hit, rd_hit, cfg_we, latch_cmd;
    acc_e              cfg_acc;
    logic [2:0]        cfg_mode;
    logic              cfg_bcd;
    logic [NCH*DW-1:0] rd_bytes;

    tmr_bus_decode #(.NCH(NCH), .DW(DW)) u_dec (
        .sel(sel), .rd(rd), .wr(wr), .addr(addr), .wdata(wdata),
        .wr_hit(wr_hit), .rd_hit(rd_hit), .cfg_we(cfg_we),
        .latch_cmd(latch_cmd), .cfg_acc(cfg_acc), .cfg_mode(cfg_mode),
        .cfg_bcd(cfg_bcd)
    );

    genvar i;
    generate
        for (i = 0; i < NCH; i++) begin : g_ch
            tmr_bus_chan #(.DW(DW)) u_ch (
                .clk(clk), .rst_n(rst_n),
                .cfg_we(cfg_we[i]), .cfg_acc(cfg_acc), .cfg_mode(cfg_mode),
                .cfg_bcd(cfg_bcd), .latch_cmd(latch_cmd[i]),
                .wr_hit(wr_hit[i]), .rd_hit(rd_hit[i]), .wdata(wdata),
                .live(live_cnt[i*CW +: CW]),
                .mode(ch_mode[i*3 +: 3]), .bcd(ch_bcd[i]),
                .ld_stb(ld_stb[i]), .ld_val(ld_val[i*CW +: CW]),
                .latch_req(latch_req[i]), .rd_byte(rd_bytes[i*DW +: DW])
            );
        end
    endgenerate

    // Read data merge: only the addressed channel drives, else zero
    always_comb begin
        rdata = '0;
        for (int k = 0; k < NCH; k++)
            if (rd_hit[k]) rdata = rd_bytes[k*DW +: DW];
    end

    p_one_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ld_stb));
    p_sel_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> (ld_stb == '0 && latch_req == '0));
endmodule

// File: tb/tmr_bus_if_tb.sv
module tmr_bus_if_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [1:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [47:0] live_cnt = '0;
    logic [8:0]  ch_mode;
    logic [2:0]  ch_bcd, ld_stb, latch_req;
    logic [47:0] ld_val;

    int checks = 0, errors = 0;

    // reference model
    logic [1:0]  m_acc [3];
    logic [2:0]  m_mode[3];
    logic        m_bcd [3];
    logic        m_wff [3], m_rff[3], m_lat[3];
    logic [7:0]  m_lo  [3];
    logic [15:0] m_hold[3];

    tmr_bus_if u_dut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .rd(rd), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(rdata), .live_cnt(live_cnt), .ch_mode(ch_mode),
        .ch_bcd(ch_bcd), .ld_stb(ld_stb), .ld_val(ld_val), .latch_req(latch_req)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(input int ch);
        logic [15:0] s;
        s = m_lat[ch] ? m_hold[ch] : live_cnt[ch*16 +: 16];
        case (m_acc[ch])
            2'b01:   return s[7:0];
            2'b10:   return s[15:8];
            default: return m_rff[ch] ? s[15:8] : s[7:0];
        endcase
    endfunction

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic check_cfg(input string tag);
        for (int c = 0; c < 3; c++) begin
            chk(ch_mode[c*3 +: 3] == m_mode[c], tag, 48'(ch_mode[c*3 +: 3]), 48'(m_mode[c]));
            chk(ch_bcd[c] == m_bcd[c], tag, 48'(ch_bcd[c]), 48'(m_bcd[c]));
        end
    endtask

    task automatic do_ctrl(input logic [7:0] d);
        int sc;
        logic [2:0] exp_lr;
        bus_wr(2'd3, d);
        sc = int'(d[7:6]);
        exp_lr = '0;
        if (sc != 3) begin
            if (d[5:4] == 2'b00) begin
                if (!m_lat[sc]) begin
                    m_lat[sc] = 1'b1;
                    m_hold[sc] = live_cnt[sc*16 +: 16];
                    exp_lr[sc] = 1'b1;
                end
            end else begin
                m_acc[sc] = d[5:4]; m_mode[sc] = d[3:1]; m_bcd[sc] = d[0];
                m_wff[sc] = 1'b0; m_rff[sc] = 1'b0;
            end
        end
        chk(latch_req == exp_lr, "R3 R4 latch_req", 48'(latch_req), 48'(exp_lr));
        check_cfg("R2 R10 config");
    endtask

    task automatic do_wr(input int ch, input logic [7:0] d);
        logic [2:0]  es;
        logic [15:0] ev;
        bus_wr(2'(ch), d);
        es = '0; ev = '0;
        case (m_acc[ch])
            2'b01: begin es[ch] = 1'b1; ev = {8'h00, d}; end
            2'b10: begin es[ch] = 1'b1; ev = {d, 8'h00}; end
            default: begin
                if (!m_wff[ch]) begin m_lo[ch] = d; m_wff[ch] = 1'b1; end
                else begin es[ch] = 1'b1; ev = {d, m_lo[ch]}; m_wff[ch] = 1'b0; end
            end
        endcase
        chk(ld_stb == es, "R6 R7 R12 ld_stb", 48'(ld_stb), 48'(es));
        if (es != 0)
            chk(ld_val[ch*16 +: 16] == ev, "R6 R7 ld_val", 48'(ld_val[ch*16 +: 16]), 48'(ev));
    endtask

    task automatic do_rd(input int ch);
        logic [7:0] e;
        e = exp_rd(ch);
        @(negedge clk);
        sel = 1'b1; rd = 1'b1; addr = 2'(ch);
        #1;
        chk(rdata == e, "R8 R4 R5 rdata", 48'(rdata), 48'(e));
        @(negedge clk);
        sel = 1'b0; rd = 1'b0;
        if (m_lat[ch] && (m_acc[ch] != 2'b11 || m_rff[ch])) m_lat[ch] = 1'b0;
        if (m_acc[ch] == 2'b11) m_rff[ch] = !m_rff[ch];
    endtask

    initial begin
        #1600000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int unused;
        unused = $urandom(32'd1234);
        for (int c = 0; c < 3; c++) begin
            m_acc[c] = 2'b11; m_mode[c] = 0; m_bcd[c] = 0;
            m_wff[c] = 0; m_rff[c] = 0; m_lat[c] = 0; m_lo[c] = 0; m_hold[c] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(ch_mode == 0 && ch_bcd == 0, "R11 cfg", 48'({ch_mode, ch_bcd}), 48'(0));
        chk(ld_stb == 0 && latch_req == 0, "R11 strobes", 48'({ld_stb, latch_req}), 48'(0));
        chk(ld_val == 0, "R11 ld_val", ld_val, 48'(0));
        // R6 word load, R7 low-only and high-only
        do_ctrl(8'h34);
        do_wr(0, 8'h34); do_wr(0, 8'h12);
        do_ctrl(8'h57); do_wr(1, 8'hAB);
        do_ctrl(8'hA0); do_wr(2, 8'hCD);
        // R3 R4 R5 latch hold, ignored relatch, release
        @(negedge clk); live_cnt[15:0] = 16'hBEEF;
        do_ctrl(8'h00);
        @(negedge clk); live_cnt[15:0] = 16'h1111;
        do_ctrl(8'h00);
        do_rd(0); do_rd(0); do_rd(0); do_rd(0);
        // R10 read-back code has no effect
        do_ctrl(8'hFF); do_ctrl(8'hC0);
        do_wr(0, 8'h55); do_wr(0, 8'h66);
        // R1 write with sel low ignored
        @(negedge clk); wr = 1'b1; addr = 2'd0; wdata = 8'h99;
        @(negedge clk); wr = 1'b0;
        chk(ld_stb == 0, "R1 sel low", 48'(ld_stb), 48'(0));
        @(negedge clk); wr = 1'b1; addr = 2'd3; wdata = 8'h12;
        @(negedge clk); wr = 1'b0;
        check_cfg("R1 sel low cfg");
        do_wr(0, 8'h01); do_wr(0, 8'h02);
        // R9 control byte resets half-done sequences
        do_wr(0, 8'h77); do_rd(0);
        do_ctrl(8'h36);
        do_wr(0, 8'h01); do_wr(0, 8'h02);
        do_rd(0); do_rd(0);
        // R8 read from control address returns 0
        @(negedge clk); sel = 1'b1; rd = 1'b1; addr = 2'd3; #1;
        chk(rdata == 0, "R8 ctrl addr read", 48'(rdata), 48'(0));
        @(negedge clk); sel = 1'b0; rd = 1'b0;
        // random phase
        for (int n = 0; n < 1500; n++) begin
            int op, ch;
            op = int'($urandom_range(0, 9));
            ch = int'($urandom_range(0, 2));
            if (op < 2) begin
                logic [7:0] d;
                d = 8'($urandom);
                if (d[5:4] == 2'b00 && $urandom_range(0, 1) == 0) d[5:4] = 2'b11;
                do_ctrl(d);
            end else if (op < 5) do_wr(ch, 8'($urandom));
            else if (op < 8) do_rd(ch);
            else begin
                @(negedge clk);
                live_cnt[ch*16 +: 16] = 16'($urandom);
            end
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule